// File: doc/BRIEF.md
# Dual-Issue Pairing and Thread Interleave Logic

This block sits at the issue stage of an in-order, two-thread core. Each hardware thread owns a small circular instruction buffer that the fetch side fills with up to four instructions per cycle. The issue logic looks at the two oldest entries of each buffer and picks one thread per cycle. It then sends the oldest instruction of that thread to slot 0. When the pairing rules allow, it also sends the next instruction of the same thread to slot 1.

The thread choice alternates between the two threads on every cycle that is not stalled. When the favoured thread has nothing it can send, the other thread takes the cycle. Pairing is refused only when both candidates belong to the same one of the four arithmetic classes: simple vector, complex vector, vector floating-point or scalar floating-point. An arithmetic instruction pairs with any instruction of a different class. Memory, fixed-point, branch and permute instructions pair with anything, including another instruction of their own class.

Each instruction carries a 3-bit class code and an opaque payload. The block reports how many entries it removed from each buffer, so that the fetch side can track the free space.

Top module: `dual_issue_pair`

## Requirements
- R1: Within a thread, instructions leave in the order they were written. Within one write, lane 0 is the oldest. `iss_cls`/`iss_pay` index 0 carries the oldest buffered entry of the selected thread, and index 1 carries the entry after it.
- R2: `acc_rdy[t]` is high exactly when thread t holds at most DEPTH-FILL entries (4 of 8 by default). A write with `wr_cnt[t]` nonzero while `acc_rdy[t]` is low is discarded, and no entry of that thread changes.
- R3: At most two instructions issue per cycle. `iss_vld[1]` is never high without `iss_vld[0]`, and both slots always come from the thread shown on `iss_thr`.
- R4: Slot 0 issues when there is no stall and the selected thread has a buffered head entry whose `op_rdy[t][0]` is high.
- R5: The class codes are 0 load/store, 1 fixed-point, 2 branch, 3 permute, 4 simple vector, 5 complex vector, 6 vector FP and 7 scalar FP. Slot 1 is refused when both candidates have the same class code in 4..7. Every other combination may pair.
- R6: Slot 1 also needs a second buffered entry in the selected thread and `op_rdy[t][1]` high.
- R7: A favoured-thread bit starts at thread 0 after reset and flips after every cycle without a stall. The favoured thread is selected when its head can issue. Otherwise the other thread is selected when its head can issue. If neither head can issue, `iss_thr` shows the favoured thread.
- R8: While `stall` is high, nothing issues, nothing is popped and the favoured-thread bit holds its value.
- R9: `pop_cnt[t]` equals the number of slots issued from thread t in that cycle. It is 0 for the thread that is not selected.
- R10: After reset, both buffers are empty, both `acc_rdy` bits are high and no slot issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cnt | input | 2x3 | Per thread, number of lanes written this cycle (0..4) |
| wr_cls | input | 2x4x3 | Per thread and lane, class code |
| wr_pay | input | 2x4xPAY_W | Per thread and lane, payload |
| acc_rdy | output | 2 | Per thread, buffer can take a full write |
| op_rdy | input | 2x2 | Per thread, operands ready for the oldest entry [0] and the next entry [1] |
| stall | input | 1 | Blocks all issue this cycle |
| iss_vld | output | 2 | Slot 0 / slot 1 issue valid |
| iss_thr | output | 1 | Selected thread |
| iss_cls | output | 2x3 | Class of the slot 0 / slot 1 instruction |
| iss_pay | output | 2xPAY_W | Payload of the slot 0 / slot 1 instruction |
| pop_cnt | output | 2x2 | Per thread, entries removed this cycle |

## Verification
The bench goes after several corner cases.

- **Same-class pairs.** It sends pairs of one arithmetic class, mixed arithmetic classes, and two memory operations. A pairing check that is too loose would dual-issue two simple-vector operations. One that is too strict would single-issue two loads.
- **Full buffer.** It fills one thread to eight entries and then writes again. Logic that accepted this write would wrap the circular buffer, and later payloads would come out in the wrong order.
- **Stall and fallback.** Stall cycles must freeze the thread alternation, or every later thread pick goes wrong. An empty or blocked favoured thread must hand the cycle to the other thread rather than waste it.
- **Second-slot readiness.** A not-ready second entry must hold slot 1 back while slot 0 still goes.

// File: rtl/dip_pkg.sv
`timescale 1ns/1ps
package dip_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_LDST     = 3'd0,
        CL_FIXED    = 3'd1,
        CL_BRANCH   = 3'd2,
        CL_PERM     = 3'd3,
        CL_VSIMPLE  = 3'd4,
        CL_VCOMPLEX = 3'd5,
        CL_VFLOAT   = 3'd6,
        CL_SFLOAT   = 3'd7
    } icls_e;

    // Arithmetic classes occupy the upper half of the code space; two of
    // the same arithmetic class compete for one pipe and cannot pair.
    function automatic logic pair_allowed(input logic [CLS_W-1:0] older,
                                          input logic [CLS_W-1:0] younger);
        logic arith;
        arith = older[CLS_W-1];
        return !(arith && (older == younger));
    endfunction

endpackage

// File: rtl/dip_thread_buf.sv
`timescale 1ns/1ps
module dip_thread_buf
    import dip_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int FILL  = 4,
    parameter int PAY_W = 8,
    parameter int WC_W  = $clog2(FILL + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WC_W-1:0]             wr_cnt,
    input  logic [FILL-1:0][CLS_W-1:0]  wr_cls,
    input  logic [FILL-1:0][PAY_W-1:0]  wr_pay,
    output logic                        acc_rdy,
    input  logic [1:0]                  pop_cnt,
    output logic [1:0]                  hd_vld,
    output logic [1:0][CLS_W-1:0]       hd_cls,
    output logic [1:0][PAY_W-1:0]       hd_pay
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [PAY_W-1:0] pay;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic take;

    always_comb begin
        acc_rdy = (st_q.cnt <= CNT_W'(DEPTH - FILL));
        take    = acc_rdy && (wr_cnt != '0);
        st_d    = st_q;
        for (int i = 0; i < FILL; i++) begin
            if (take && (WC_W'(i) < wr_cnt)) begin
                st_d.mem[PTR_W'(st_q.rd + st_q.cnt[PTR_W-1:0] + PTR_W'(i))] =
                    '{cls: wr_cls[i], pay: wr_pay[i]};
            end
        end
        st_d.rd  = st_q.rd + PTR_W'(pop_cnt);
        st_d.cnt = st_q.cnt - CNT_W'(pop_cnt) + (take ? CNT_W'(wr_cnt) : '0);
    end

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            hd_vld[k] = (st_q.cnt > CNT_W'(k));
            hd_cls[k] = st_q.mem[PTR_W'(st_q.rd + PTR_W'(k))].cls;
            hd_pay[k] = st_q.mem[PTR_W'(st_q.rd + PTR_W'(k))].pay;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    p_refuse_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rdy && (wr_cnt != '0)) |=> (st_q.cnt <= $past(st_q.cnt)));

    p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= WC_W'(FILL));

    p_pop_le_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_cnt) <= st_q.cnt);

endmodule

// File: rtl/dip_issue_sel.sv
`timescale 1ns/1ps
module dip_issue_sel
    import dip_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        stall,
    input  logic [1:0][1:0]             hd_vld,
    input  logic [1:0][1:0]             op_rdy,
    input  logic [1:0][1:0][CLS_W-1:0]  hd_cls,
    output logic [1:0]                  iss_vld,
    output logic                        iss_thr,
    output logic [1:0][1:0]             pop_cnt
);

    typedef struct packed {
        logic fav;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] thr_go;
    logic       sel;

    always_comb begin
        for (int t = 0; t < 2; t++) begin
            thr_go[t] = hd_vld[t][0] && op_rdy[t][0];
        end
        sel = st_q.fav;
        if (!thr_go[st_q.fav] && thr_go[~st_q.fav]) sel = ~st_q.fav;

        iss_vld[0] = !stall && thr_go[sel];
        iss_vld[1] = iss_vld[0] && hd_vld[sel][1] && op_rdy[sel][1] &&
                     pair_allowed(hd_cls[sel][0], hd_cls[sel][1]);
        iss_thr    = sel;

        pop_cnt      = '0;
        pop_cnt[sel] = {1'b0, iss_vld[0]} + {1'b0, iss_vld[1]};

        st_d     = st_q;
        st_d.fav = stall ? st_q.fav : ~st_q.fav;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_slot1_needs_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[1] |-> iss_vld[0]);

    p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((iss_vld == 2'b00) && (pop_cnt == '0)));

    p_fav_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(st_q.fav));

    p_fav_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (st_q.fav != $past(st_q.fav)));

    p_no_same_arith_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[1] |-> !(hd_cls[iss_thr][0][CLS_W-1] &&
                         (hd_cls[iss_thr][0] == hd_cls[iss_thr][1])));

    p_slot1_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[1] |-> (hd_vld[iss_thr][1] && op_rdy[iss_thr][1]));

    p_slot0_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[0] |-> (hd_vld[iss_thr][0] && op_rdy[iss_thr][0]));

endmodule

// File: rtl/dual_issue_pair.sv
`timescale 1ns/1ps
module dual_issue_pair
    import dip_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int FILL  = 4,
    parameter int PAY_W = 8,
    parameter int WC_W  = $clog2(FILL + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0][WC_W-1:0]              wr_cnt,
    input  logic [1:0][FILL-1:0][CLS_W-1:0]   wr_cls,
    input  logic [1:0][FILL-1:0][PAY_W-1:0]   wr_pay,
    output logic [1:0]                        acc_rdy,
    input  logic [1:0][1:0]                   op_rdy,
    input  logic                              stall,
    output logic [1:0]                        iss_vld,
    output logic                              iss_thr,
    output logic [1:0][CLS_W-1:0]             iss_cls,
    output logic [1:0][PAY_W-1:0]             iss_pay,
    output logic [1:0][1:0]                   pop_cnt
);

    localparam int NTHR = 2;

    logic [NTHR-1:0][1:0]             hd_vld;
    logic [NTHR-1:0][1:0][CLS_W-1:0]  hd_cls;
    logic [NTHR-1:0][1:0][PAY_W-1:0]  hd_pay;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        dip_thread_buf #(
            .DEPTH (DEPTH),
            .FILL  (FILL),
            .PAY_W (PAY_W),
            .WC_W  (WC_W)
        ) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cnt  (wr_cnt[t]),
            .wr_cls  (wr_cls[t]),
            .wr_pay  (wr_pay[t]),
            .acc_rdy (acc_rdy[t]),
            .pop_cnt (pop_cnt[t]),
            .hd_vld  (hd_vld[t]),
            .hd_cls  (hd_cls[t]),
            .hd_pay  (hd_pay[t])
        );
    end

    dip_issue_sel u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .hd_vld  (hd_vld),
        .op_rdy  (op_rdy),
        .hd_cls  (hd_cls),
        .iss_vld (iss_vld),
        .iss_thr (iss_thr),
        .pop_cnt (pop_cnt)
    );

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            iss_cls[k] = hd_cls[iss_thr][k];
            iss_pay[k] = hd_pay[iss_thr][k];
        end
    end

    p_idle_thread_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_cnt[~iss_thr] == 2'd0);

    p_pop_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_cnt[iss_thr] == (2'(iss_vld[0]) + 2'(iss_vld[1])));

endmodule

// File: tb/sim_dual_issue_pair.sv
`timescale 1ns/1ps
module sim_dual_issue_pair;

    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int FILL  = 4;
    localparam int PAY_W = 8;

    typedef struct packed {
        logic [2:0]       cls;
        logic [PAY_W-1:0] pay;
    } ment_t;

    logic                          clk = 0;
    logic                          rst_n;
    logic [1:0][2:0]               wr_cnt;
    logic [1:0][FILL-1:0][2:0]     wr_cls;
    logic [1:0][FILL-1:0][PAY_W-1:0] wr_pay;
    logic [1:0]                    acc_rdy;
    logic [1:0][1:0]               op_rdy;
    logic                          stall;
    logic [1:0]                    iss_vld;
    logic                          iss_thr;
    logic [1:0][2:0]               iss_cls;
    logic [1:0][PAY_W-1:0]         iss_pay;
    logic [1:0][1:0]               pop_cnt;

    int    nchk = 0;
    int    nfail = 0;
    int    fav = 0;
    int    nxt [2];
    ment_t q0[$];
    ment_t q1[$];

    dual_issue_pair #(.DEPTH(DEPTH), .FILL(FILL), .PAY_W(PAY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_cls(wr_cls),
        .wr_pay(wr_pay), .acc_rdy(acc_rdy), .op_rdy(op_rdy), .stall(stall),
        .iss_vld(iss_vld), .iss_thr(iss_thr), .iss_cls(iss_cls),
        .iss_pay(iss_pay), .pop_cnt(pop_cnt)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int qsz(int t);
        return (t == 0) ? q0.size() : q1.size();
    endfunction

    function automatic ment_t qat(int t, int k);
        return (t == 0) ? q0[k] : q1[k];
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_cnt = '0;
        wr_cls = '0;
        wr_pay = '0;
    endtask

    task automatic put(int t, int n, int c0, int c1, int c2, int c3);
        int cs[4];
        cs = '{c0, c1, c2, c3};
        wr_cnt[t] = 3'(n);
        for (int i = 0; i < FILL; i++) begin
            wr_cls[t][i] = 3'(cs[i]);
            wr_pay[t][i] = PAY_W'(nxt[t] + i);
        end
        nxt[t] += n;
    endtask

    // Compare one cycle against the model, then advance the model across
    // the coming rising edge.
    task automatic step();
        bit    go[2];
        int    acc[2];
        int    sel, e0, e1;
        ment_t a, b;
        #1;
        for (int t = 0; t < 2; t++) begin
            go[t]  = (qsz(t) > 0) && op_rdy[t][0];
            acc[t] = (qsz(t) <= DEPTH - FILL);
        end
        sel = go[fav] ? fav : (go[1-fav] ? 1 - fav : fav);
        e0  = (!stall && go[sel]) ? 1 : 0;
        e1  = 0;
        if (e0 == 1 && qsz(sel) > 1 && op_rdy[sel][1]) begin
            a  = qat(sel, 0);
            b  = qat(sel, 1);
            e1 = (a.cls >= 4 && a.cls == b.cls) ? 0 : 1;
        end
        for (int t = 0; t < 2; t++) begin
            chk($sformatf("R2 acc_rdy thread %0d", t), int'(acc_rdy[t]), acc[t]);
            chk($sformatf("R9 pop_cnt thread %0d", t), int'(pop_cnt[t]),
                (t == sel) ? e0 + e1 : 0);
        end
        chk("R4 slot0 valid", int'(iss_vld[0]), e0);
        chk("R5 R6 slot1 valid", int'(iss_vld[1]), e1);
        chk("R3 slot1 without slot0", int'(iss_vld[1] && !iss_vld[0]), 0);
        chk("R7 selected thread", int'(iss_thr), sel);
        if (stall) chk("R8 issue under stall", int'(iss_vld), 0);
        if (e0 == 1) begin
            a = qat(sel, 0);
            chk("R1 slot0 class", int'(iss_cls[0]), int'(a.cls));
            chk("R1 slot0 payload", int'(iss_pay[0]), int'(a.pay));
        end
        if (e1 == 1) begin
            b = qat(sel, 1);
            chk("R1 slot1 class", int'(iss_cls[1]), int'(b.cls));
            chk("R1 slot1 payload", int'(iss_pay[1]), int'(b.pay));
        end
        for (int n = 0; n < e0 + e1; n++) begin
            if (sel == 0) void'(q0.pop_front());
            else          void'(q1.pop_front());
        end
        for (int t = 0; t < 2; t++) begin
            if (wr_cnt[t] != 0 && acc[t] == 1) begin
                for (int i = 0; i < int'(wr_cnt[t]); i++) begin
                    if (t == 0) q0.push_back('{cls: wr_cls[t][i], pay: wr_pay[t][i]});
                    else        q1.push_back('{cls: wr_cls[t][i], pay: wr_pay[t][i]});
                end
            end
        end
        if (!stall) fav = 1 - fav;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        nxt = '{0, 0};
        rst_n  = 0;
        stall  = 0;
        op_rdy = '1;
        idle();
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset no issue", int'(iss_vld), 0);
        chk("R10 reset acc_rdy", int'(acc_rdy), 3);
        chk("R10 reset pop", int'(pop_cnt), 0);
        rst_n = 1;

        // R5: two simple-vector ops must split; then mixed and memory pairs
        put(0, 2, 4, 4, 0, 0); step(); idle(); repeat (3) step();
        put(0, 4, 6, 7, 0, 0); step(); idle(); repeat (4) step();
        put(1, 4, 5, 5, 4, 3); step(); idle(); repeat (4) step();

        // R6: second entry not ready blocks slot1 only
        op_rdy[0][1] = 0;
        put(0, 2, 0, 1, 0, 0); step(); idle(); repeat (3) step();
        op_rdy = '1;

        // R2: fill thread 1 to eight entries, then a refused write
        op_rdy = '0;
        put(1, 4, 7, 7, 2, 3); step();
        put(1, 4, 1, 1, 6, 6); step();
        put(1, 2, 0, 0, 0, 0); step();
        idle(); step();
        // R8: stall with ready work freezes issue and alternation
        op_rdy = '1;
        stall  = 1; repeat (3) step();
        stall  = 0; repeat (8) step();

        // R7: only thread 1 has work while thread 0 is favoured
        put(1, 3, 0, 4, 4, 0); step(); idle(); repeat (4) step();

        // randomised traffic
        repeat (4000) begin
            idle();
            stall = ($urandom_range(0, 9) == 0);
            for (int t = 0; t < 2; t++) begin
                for (int k = 0; k < 2; k++) op_rdy[t][k] = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 1) == 1)
                    put(t, $urandom_range(0, 4), $urandom_range(0, 7),
                        $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
            end
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule